// File: doc/BRIEF.md
# APB3 Control and Status Register Block

This block is an APB3 slave holding four 32-bit registers whose bit-fields each have their own access behaviour. A control word carries a run enable, a mode selector and a self-clearing kick bit. A status word mirrors a hardware input. An interrupt word holds sticky flags that hardware sets and software clears by writing ones. A command word is write-only: it drives a hardware output and always reads back as zero. Each field is its own storage element with its own hardware port.

Writes take effect at the clock edge that ends the access phase. Reads are served combinationally from the address decode. The slave never inserts wait states and never signals an error. A system integrator wires the bus pins to an APB master or bridge, and wires the field ports to the hardware being controlled.

Top module: `csr_apb_regs`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the following values are loaded: `run_en_o`=0, `op_mode_o`=2'b01, `cmd_o`=0, `irq_o`=0 and `kick_o`=0.
- R2: `apb_ready` is always 1 and `apb_err` is always 0.
- R3: A register changes only at a rising edge where `apb_sel`, `apb_en` and `apb_write` are all high. A setup phase or a read access phase leaves every stored field unchanged.
- R4: The control word (index 0, offset 0x0) holds `run_en_o` at bit 0 and `op_mode_o` at bits 2:1. Both are read-write and read back as written.
- R5: Writing 1 to control bit 3 raises `kick_o` for exactly the one cycle after the committing edge. Writing 0 to that bit raises no pulse, and bit 3 always reads 0.
- R6: The status word (index 1, offset 0x4) returns `sts_i` in bits 7:0 and 0 above them. Writes to it change nothing.
- R7: The interrupt word (index 2, offset 0x8) has 4 sticky bits. A bit is set by a high `irq_set_i` bit and is cleared by a committed write with a 1 in that bit position. A 0 in a written bit keeps that bit. The value is driven on `irq_o` and read back in bits 3:0.
- R8: When a set and a software clear hit the same interrupt bit in the same cycle, the set wins and the bit is 1.
- R9: A write to the command word (index 3, offset 0xC) loads bits 15:0 onto `cmd_o`, which holds that value until the next such write. Reads of this word return 0.
- R10: Only `apb_addr[3:2]` selects the word, so higher address bits alias. Bit positions with no field read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| apb_sel | input | 1 | Slave select |
| apb_en | input | 1 | Access-phase strobe |
| apb_write | input | 1 | 1 = write, 0 = read |
| apb_addr | input | 12 | Byte address |
| apb_wdata | input | 32 | Write data |
| apb_rdata | output | 32 | Read data (combinational) |
| apb_ready | output | 1 | Transfer ready, constant 1 |
| apb_err | output | 1 | Slave error, constant 0 |
| run_en_o | output | 1 | Run enable field |
| op_mode_o | output | 2 | Mode field |
| kick_o | output | 1 | One-cycle kick pulse |
| sts_i | input | 8 | Hardware status shown in the status word |
| irq_set_i | input | 4 | Per-bit set requests for the sticky flags |
| irq_o | output | 4 | Current sticky flag values |
| cmd_o | output | 16 | Write-only command value |

## Verification
The hardest situation to bring about is a hardware set landing on an interrupt bit in the very cycle that software's write-one-to-clear commits. Reaching it needs the set input to be aligned with the access phase of a bus write. The bench's transfer task can assert a chosen set mask exactly during the access phase. Directed cases place a set on a bit that is being cleared, and random transfers mix random set masks into random writes to the interrupt word, so both the winning set and the partial clears of the other bits are checked against the bench's model.

// File: rtl/csr_pkg.sv
// Package: register indices and fixed field positions shared by the
// register block, its checker and the bench. Word selection uses the
// two address bits above the byte offset.
package csr_pkg;
    typedef enum logic [1:0] {
        IDX_CTL = 2'd0,
        IDX_STS = 2'd1,
        IDX_IRQ = 2'd2,
        IDX_CMD = 2'd3
    } reg_idx_e;

    localparam int IDX_LSB      = 2;   // word index lives in addr[3:2]
    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_MODE_LSB = 1;
endpackage

// File: rtl/csr_rw_field.sv
// Module: one stored read-write (or write-only) field.
// Assumes: the caller presents an already decoded write strobe and the
// field slice of the write data; reset is synchronous and active-low.
module csr_rw_field #(
    parameter int             W   = 1,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load the field on a committed write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d;
    end
endmodule

// File: rtl/csr_w1c_bits.sv
// Module: a vector of sticky flags, set by hardware, cleared by writing 1.
// Assumes: clr is the committed write data masked by the write strobe;
// a set in the same cycle as a clear keeps the bit high.
module csr_w1c_bits #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit update: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/csr_pulse.sv
// Module: self-clearing trigger. Registers a request so the output is
// high only in the cycle after the request was seen.
// Assumes: requests come from committed writes, which are never on
// consecutive edges under APB, so each pulse is isolated.
module csr_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);
    // Capture the request for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= req;
    end
endmodule

// File: rtl/csr_read_mux.sv
// Module: combinational read selector over the four register words.
// Assumes: each word input is already zero-filled where no readable
// field exists.
module csr_read_mux #(
    parameter int DW = 32
) (
    input  csr_pkg::reg_idx_e idx,
    input  logic [DW-1:0]     w_ctl,
    input  logic [DW-1:0]     w_sts,
    input  logic [DW-1:0]     w_irq,
    input  logic [DW-1:0]     w_cmd,
    output logic [DW-1:0]     rdata
);
    // Pick the word addressed by the index.
    always_comb begin
        unique case (idx)
            csr_pkg::IDX_CTL: rdata = w_ctl;
            csr_pkg::IDX_STS: rdata = w_sts;
            csr_pkg::IDX_IRQ: rdata = w_irq;
            default:          rdata = w_cmd;
        endcase
    end
endmodule

// File: rtl/csr_apb_regs.sv
// Module: APB3 slave with four field-structured registers: control
// (read-write fields plus a kick pulse), status (read-only), interrupt
// (write-one-to-clear) and command (write-only).
// Assumes: zero wait states, no error response, full-word writes;
// synchronous active-low reset.
module csr_apb_regs #(
    parameter int                ADDR_W   = 12,
    parameter int                DATA_W   = 32,
    parameter int                MODE_W   = 2,
    parameter logic [MODE_W-1:0] MODE_RST = 2'b01,
    parameter int                STS_W    = 8,
    parameter int                IRQ_W    = 4,
    parameter int                CMD_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apb_sel,
    input  logic              apb_en,
    input  logic              apb_write,
    input  logic [ADDR_W-1:0] apb_addr,
    input  logic [DATA_W-1:0] apb_wdata,
    output logic [DATA_W-1:0] apb_rdata,
    output logic              apb_ready,
    output logic              apb_err,
    output logic              run_en_o,
    output logic [MODE_W-1:0] op_mode_o,
    output logic              kick_o,
    input  logic [STS_W-1:0]  sts_i,
    input  logic [IRQ_W-1:0]  irq_set_i,
    output logic [IRQ_W-1:0]  irq_o,
    output logic [CMD_W-1:0]  cmd_o
);
    import csr_pkg::*;

    localparam int KICK_BIT = CTL_MODE_LSB + MODE_W;

    reg_idx_e    idx;
    logic        commit;
    logic        we_ctl, we_irq, we_cmd;
    logic [IRQ_W-1:0] irq_clr;
    logic [DATA_W-1:0] w_ctl, w_sts, w_irq, w_cmd;

    // Fixed transfer responses: no wait states, no errors.
    assign apb_ready = 1'b1;
    assign apb_err   = 1'b0;

    // Decode the word index and the committing access phase.
    always_comb begin
        idx    = reg_idx_e'(apb_addr[IDX_LSB +: 2]);
        commit = apb_sel && apb_en && apb_write;
        we_ctl = commit && (idx == IDX_CTL);
        we_irq = commit && (idx == IDX_IRQ);
        we_cmd = commit && (idx == IDX_CMD);
        irq_clr = we_irq ? apb_wdata[IRQ_W-1:0] : '0;
    end

    csr_rw_field #(.W(1), .RST(1'b0)) u_run (
        .clk(clk), .rst_n(rst_n), .we(we_ctl),
        .d(apb_wdata[CTL_RUN_BIT]), .q(run_en_o)
    );

    csr_rw_field #(.W(MODE_W), .RST(MODE_RST)) u_mode (
        .clk(clk), .rst_n(rst_n), .we(we_ctl),
        .d(apb_wdata[CTL_MODE_LSB +: MODE_W]), .q(op_mode_o)
    );

    csr_pulse u_kick (
        .clk(clk), .rst_n(rst_n),
        .req(we_ctl && apb_wdata[KICK_BIT]), .pulse(kick_o)
    );

    csr_w1c_bits #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(irq_set_i), .clr(irq_clr), .q(irq_o)
    );

    csr_rw_field #(.W(CMD_W), .RST('0)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(we_cmd),
        .d(apb_wdata[CMD_W-1:0]), .q(cmd_o)
    );

    // Assemble readable words; kick and command read as zero.
    always_comb begin
        w_ctl = '0;
        w_ctl[CTL_RUN_BIT] = run_en_o;
        w_ctl[CTL_MODE_LSB +: MODE_W] = op_mode_o;
        w_sts = '0;
        w_sts[STS_W-1:0] = sts_i;
        w_irq = '0;
        w_irq[IRQ_W-1:0] = irq_o;
        w_cmd = '0;
    end

    csr_read_mux #(.DW(DATA_W)) u_rmux (
        .idx(idx), .w_ctl(w_ctl), .w_sts(w_sts), .w_irq(w_irq),
        .w_cmd(w_cmd), .rdata(apb_rdata)
    );
endmodule

// File: rtl/csr_apb_regs_chk.sv
// Module: property checker bound to the register block. Observes ports
// only; holds no model of the register contents.
module csr_apb_regs_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int MODE_W = 2,
    parameter int STS_W  = 8,
    parameter int IRQ_W  = 4,
    parameter int CMD_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              apb_sel,
    input logic              apb_en,
    input logic              apb_write,
    input logic [ADDR_W-1:0] apb_addr,
    input logic [DATA_W-1:0] apb_wdata,
    input logic [DATA_W-1:0] apb_rdata,
    input logic              run_en_o,
    input logic [MODE_W-1:0] op_mode_o,
    input logic              kick_o,
    input logic [STS_W-1:0]  sts_i,
    input logic [IRQ_W-1:0]  irq_set_i,
    input logic [IRQ_W-1:0]  irq_o,
    input logic [CMD_W-1:0]  cmd_o
);
    localparam int KICK_BIT = 1 + MODE_W;

    // R5: the kick never lasts two cycles.
    a_r5_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> !kick_o);

    // R5: a kick is always caused by a committed control write with bit 3 set.
    a_r5_kick_cause: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |-> $past(apb_sel && apb_en && apb_write &&
                         apb_addr[3:2] == 2'd0 && apb_wdata[KICK_BIT]));

    // R3: without a committed write, stored fields hold.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(apb_sel && apb_en && apb_write) |=>
            ($stable(run_en_o) && $stable(op_mode_o) && $stable(cmd_o)));

    // R8: a set request always leaves its bit high.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_set_i != '0) |=> ((irq_o & $past(irq_set_i)) == $past(irq_set_i)));

    // R6: the status word reflects the hardware input.
    a_r6_sts_read: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_addr[3:2] == 2'd1) |->
            (apb_rdata == DATA_W'(sts_i)));

    // R9: the command word reads zero.
    a_r9_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (apb_sel && apb_addr[3:2] == 2'd3) |-> (apb_rdata == '0));
endmodule

bind csr_apb_regs csr_apb_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W),
    .STS_W(STS_W), .IRQ_W(IRQ_W), .CMD_W(CMD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .apb_sel(apb_sel), .apb_en(apb_en),
    .apb_write(apb_write), .apb_addr(apb_addr), .apb_wdata(apb_wdata),
    .apb_rdata(apb_rdata), .run_en_o(run_en_o), .op_mode_o(op_mode_o),
    .kick_o(kick_o), .sts_i(sts_i), .irq_set_i(irq_set_i), .irq_o(irq_o),
    .cmd_o(cmd_o)
);

// File: tb/csr_apb_regs_test.sv
`timescale 1ns/1ps
module csr_apb_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apb_sel = 1'b0, apb_en = 1'b0, apb_write = 1'b0;
    logic [11:0] apb_addr = '0;
    logic [31:0] apb_wdata = '0;
    logic [31:0] apb_rdata;
    logic        apb_ready, apb_err;
    logic        run_en_o, kick_o;
    logic [1:0]  op_mode_o;
    logic [7:0]  sts_i = '0;
    logic [3:0]  irq_set_i = '0;
    logic [3:0]  irq_o;
    logic [15:0] cmd_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model state
    bit        m_run;
    bit [1:0]  m_mode;
    bit [3:0]  m_irq;
    bit [15:0] m_cmd;

    always #4 clk = ~clk;   // 125 MHz

    csr_apb_regs uut (
        .clk(clk), .rst_n(rst_n), .apb_sel(apb_sel), .apb_en(apb_en),
        .apb_write(apb_write), .apb_addr(apb_addr), .apb_wdata(apb_wdata),
        .apb_rdata(apb_rdata), .apb_ready(apb_ready), .apb_err(apb_err),
        .run_en_o(run_en_o), .op_mode_o(op_mode_o), .kick_o(kick_o),
        .sts_i(sts_i), .irq_set_i(irq_set_i), .irq_o(irq_o), .cmd_o(cmd_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a[3:2])
            2'd0:    return {29'd0, m_mode, m_run};
            2'd1:    return {24'd0, sts_i};
            2'd2:    return {28'd0, m_irq};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check_outputs(input string tag);
        chk({tag, " run_en"}, 32'(run_en_o), 32'(m_run));
        chk({tag, " mode"},   32'(op_mode_o), 32'(m_mode));
        chk({tag, " irq"},    32'(irq_o), 32'(m_irq));
        chk({tag, " cmd"},    32'(cmd_o), 32'(m_cmd));
        chk("R2 ready/err", {30'd0, apb_ready, apb_err}, 32'b10);
    endtask

    // One full transfer starting at a falling edge; setm is driven in the access phase.
    task automatic xfer(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] setm, input string tag);
        logic [31:0] e;
        bit kick_exp;
        apb_sel = 1'b1; apb_en = 1'b0; apb_write = wr; apb_addr = a; apb_wdata = d;
        @(posedge clk); @(negedge clk);
        apb_en = 1'b1; irq_set_i = setm;
        #1;
        if (!wr) chk({tag, " read"}, apb_rdata, exp_read(a));
        @(posedge clk); @(negedge clk);
        apb_sel = 1'b0; apb_en = 1'b0; apb_write = 1'b0; irq_set_i = '0;
        kick_exp = wr && a[3:2] == 2'd0 && d[3];
        // model update for the commit edge
        if (wr && a[3:2] == 2'd0) begin m_run = d[0]; m_mode = d[2:1]; end
        if (wr && a[3:2] == 2'd3) m_cmd = d[15:0];
        m_irq = setm | (m_irq & ~((wr && a[3:2] == 2'd2) ? d[3:0] : 4'd0));
        chk("R5 kick after commit", 32'(kick_o), 32'(kick_exp));
        check_outputs(tag);
        @(posedge clk); @(negedge clk);
        chk("R5 kick gone", 32'(kick_o), 32'd0);
    endtask

    // watchdog
    initial begin
        #1600000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_run = 0; m_mode = 2'b01; m_irq = 0; m_cmd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_outputs("R1 reset");
        chk("R1 kick reset", 32'(kick_o), 32'd0);

        // R4 / R5 directed
        xfer(1, 12'h000, 32'h0000_0005, 4'd0, "R4 ctl write");
        xfer(0, 12'h000, 32'd0, 4'd0, "R4 ctl read");
        xfer(1, 12'h000, 32'h0000_000B, 4'd0, "R5 kick write");
        xfer(0, 12'h000, 32'd0, 4'd0, "R5 bit3 reads 0");

        // R3: setup phase only, then a read access with data present
        apb_sel = 1; apb_write = 1; apb_addr = 12'h000; apb_wdata = 32'h6;
        @(posedge clk); @(negedge clk);
        apb_sel = 0; apb_write = 0;
        check_outputs("R3 setup only");
        xfer(0, 12'h00C, 32'hFFFF_FFFF, 4'd0, "R3 read no write");

        // R6: status mirrors input and ignores writes
        sts_i = 8'hA5;
        xfer(1, 12'h004, 32'hFFFF_FFFF, 4'd0, "R6 sts write");
        xfer(0, 12'h004, 32'd0, 4'd0, "R6 sts read");

        // R7 / R8
        irq_set_i = 4'b0110; @(posedge clk); @(negedge clk); irq_set_i = 0;
        m_irq = 4'b0110;
        check_outputs("R7 hw set");
        xfer(1, 12'h008, 32'h0000_0009, 4'd0, "R7 clear of zero bits keeps");
        xfer(1, 12'h008, 32'h0000_0002, 4'd0, "R7 clear bit1");
        xfer(1, 12'h008, 32'h0000_0004, 4'b0100, "R8 set wins");
        xfer(0, 12'h008, 32'd0, 4'd0, "R8 read back");

        // R9
        xfer(1, 12'h00C, 32'hDEAD_BEEF, 4'd0, "R9 cmd write");
        xfer(0, 12'h00C, 32'd0, 4'd0, "R9 cmd reads 0");

        // R10 aliasing
        xfer(1, 12'h100, 32'hFFFF_FFF2, 4'd0, "R10 alias write");
        xfer(0, 12'hF00, 32'd0, 4'd0, "R10 alias read");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            a = 12'($urandom) & 12'hFFC;
            sts_i = 8'($urandom);
            xfer(1'($urandom), a, $urandom, 4'($urandom & ($urandom & 32'hF)),
                 "R3 R4 R7 R9 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule